// File: doc/BRIEF.md
# SPI Interrupt Status and Masking Unit

This block gathers three event pulses from an SPI controller (transfer finished, receive data ready and receive overflow) into sticky raw status bits. It gates those bits with three enable bits held in the controller's control word, and drives a single level-sensitive interrupt line. Software uses a small register window to clear raw bits by writing ones and to read the control word, the raw bits, the masked bits and a status summary.

The enables sit at different bit positions in the control word from the status bits they gate, so a remapping stage lines them up. The interrupt line is registered. It follows a change of a raw bit or an enable one clock later. The raw, masked and status registers are read-only, and a write to any of them changes nothing.

Top module: `iss_top`

## Requirements
- R1: After reset the control register reads 0x80000102, and the raw status, masked status and status reads and the interrupt output are all zero.
- R2: A pulse on evt_tx_done_i, evt_rx_ready_i or evt_rx_overflow_i sets raw status bit 0, 1 or 2 respectively, visible on the clock after the pulse. The bit stays set until it is cleared.
- R3: A write to the clear address (2) clears each raw bit whose data bit (0, 1 or 2) is 1. Raw bits whose data bit is 0 are unchanged.
- R4: When an event pulse and a clear of the same bit fall in the same cycle, the raw bit ends up set.
- R5: Masked status (address 3) bit 0 is raw bit 0 AND control bit 5, bit 1 is raw bit 1 AND control bit 4, and bit 2 is raw bit 2 AND control bit 6. All higher bits read 0.
- R6: irq_o is the OR of the masked bits as they stood one clock earlier.
- R7: Writes to the status (1), masked (3) and raw (4) addresses change no register.
- R8: A write to the control address (0) stores the whole 32-bit word, and the word reads back unchanged.
- R9: The status read (address 1) returns the raw bits in bits 2:0 and the interrupt output in bit 3, with zeros above. Raw status reads at address 4 in bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| evt_tx_done_i | input | 1 | Transfer-finished event pulse |
| evt_rx_ready_i | input | 1 | Receive-data-ready event pulse |
| evt_rx_overflow_i | input | 1 | Receive overflow event pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register read address (combinational read) |
| rd_data_o | output | 32 | Register read data |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The assertions check the rules that hold on every cycle: raw bits stay set without a clear, an event sets its bit, a clear without a colliding event empties its bit, masked bits never exceed raw bits, writes to read-only addresses leave the raw bits alone, and the interrupt follows the masked bits one clock later. The bench sweeps every raw pattern against every enable combination and computes the expected masked value and interrupt level. Those scenarios are what show the crossed enable-to-status mapping, the status word layout, the reset values, the control readback and the event-wins collision.

// File: rtl/iss_pkg.sv
package iss_pkg;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned ADDR_W  = 3;
    localparam int unsigned NUM_EVT = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd1;
    localparam logic [ADDR_W-1:0] A_CLEAR  = 3'd2;
    localparam logic [ADDR_W-1:0] A_MASKED = 3'd3;
    localparam logic [ADDR_W-1:0] A_RAW    = 3'd4;

    localparam logic [DATA_W-1:0] CTRL_RESET = 32'h8000_0102;

    // control-word position of the enable gating status bit n
    localparam int unsigned EN_POS [NUM_EVT] = '{5, 4, 6};

    localparam int unsigned STAT_IRQ_BIT = NUM_EVT;

    typedef struct packed {
        logic [NUM_EVT-1:0] bits;
    } raw_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] word;
    } ctrl_state_t;

    typedef struct packed {
        logic level;
    } irq_state_t;
endpackage

// File: rtl/iss_raw_status.sv
module iss_raw_status
    import iss_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               clr_en_i,
    input  logic [NUM_EVT-1:0] clr_bits_i,
    output logic [NUM_EVT-1:0] raw_o
);
    raw_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < int'(NUM_EVT); b++) begin
            if (clr_en_i && clr_bits_i[b]) begin
                st_d.bits[b] = 1'b0;
            end
            // an event in the same cycle overrides the clear
            if (evt_i[b]) begin
                st_d.bits[b] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_o = st_q.bits;
endmodule

// File: rtl/iss_ctrl_reg.sv
module iss_ctrl_reg
    import iss_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] ctrl_o
);
    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.word = wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.word <= CTRL_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o = st_q.word;
endmodule

// File: rtl/iss_enable_map.sv
module iss_enable_map
    import iss_pkg::*;
(
    input  logic [DATA_W-1:0]  ctrl_i,
    input  logic [NUM_EVT-1:0] raw_i,
    output logic [NUM_EVT-1:0] masked_o
);
    logic [NUM_EVT-1:0] en;

    for (genvar g = 0; g < int'(NUM_EVT); g++) begin : g_map
        assign en[g]       = ctrl_i[EN_POS[g]];
        assign masked_o[g] = raw_i[g] & en[g];
    end
endmodule

// File: rtl/iss_irq_reg.sv
module iss_irq_reg
    import iss_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_EVT-1:0] masked_i,
    output logic               irq_o
);
    irq_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.level = |masked_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.level;
endmodule

// File: rtl/iss_top.sv
module iss_top
    import iss_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              evt_tx_done_i,
    input  logic              evt_rx_ready_i,
    input  logic              evt_rx_overflow_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);
    logic [NUM_EVT-1:0] evt_vec;
    logic               clr_hit;
    logic               ctrl_we;
    logic               ro_wr;
    logic [DATA_W-1:0]  ctrl_q;
    logic [NUM_EVT-1:0] raw_q;
    logic [NUM_EVT-1:0] masked;
    logic               irq_q;

    assign evt_vec = {evt_rx_overflow_i, evt_rx_ready_i, evt_tx_done_i};
    assign clr_hit = wr_en_i && (wr_addr_i == A_CLEAR);
    assign ctrl_we = wr_en_i && (wr_addr_i == A_CTRL);
    assign ro_wr   = wr_en_i && ((wr_addr_i == A_STATUS) ||
                                 (wr_addr_i == A_MASKED) ||
                                 (wr_addr_i == A_RAW));

    iss_ctrl_reg u_ctrl (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (ctrl_we),
        .wdata_i (wr_data_i),
        .ctrl_o  (ctrl_q)
    );

    iss_raw_status u_raw (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .evt_i      (evt_vec),
        .clr_en_i   (clr_hit),
        .clr_bits_i (wr_data_i[NUM_EVT-1:0]),
        .raw_o      (raw_q)
    );

    iss_enable_map u_map (
        .ctrl_i   (ctrl_q),
        .raw_i    (raw_q),
        .masked_o (masked)
    );

    iss_irq_reg u_irq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .masked_i (masked),
        .irq_o    (irq_q)
    );

    always_comb begin
        rd_data_o = '0;
        unique case (rd_addr_i)
            A_CTRL:   rd_data_o = ctrl_q;
            A_STATUS: begin
                rd_data_o[NUM_EVT-1:0]  = raw_q;
                rd_data_o[STAT_IRQ_BIT] = irq_q;
            end
            A_MASKED: rd_data_o[NUM_EVT-1:0] = masked;
            A_RAW:    rd_data_o[NUM_EVT-1:0] = raw_q;
            default:  rd_data_o = '0;
        endcase
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/iss_checker.sv
module iss_checker
    import iss_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_EVT-1:0] evt,
    input logic               clr_hit,
    input logic [NUM_EVT-1:0] clr_bits,
    input logic               ro_wr,
    input logic [NUM_EVT-1:0] raw,
    input logic [NUM_EVT-1:0] masked,
    input logic               irq
);
    for (genvar g = 0; g < int'(NUM_EVT); g++) begin : g_bit
        // R2: set bits are sticky without a clear
        assert_raw_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (raw[g] && !(clr_hit && clr_bits[g])) |=> raw[g]);
        // R2 / R4: an event always leaves its bit set
        assert_event_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
            evt[g] |=> raw[g]);
        // R3: clear without a colliding event empties the bit
        assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_hit && clr_bits[g] && !evt[g]) |=> !raw[g]);
    end

    // R5: masked never exceeds raw
    assert_masked_subset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (masked & ~raw) == '0);

    // R6: interrupt follows masked bits one clock later
    assert_irq_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == (|$past(masked))));

    // R7: read-only writes with no events leave raw unchanged
    assert_ro_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ro_wr && evt == '0) |=> $stable(raw));
endmodule

bind iss_top iss_checker u_iss_checker (
    .clk      (clk_i),
    .rst_n    (rst_ni),
    .evt      (evt_vec),
    .clr_hit  (clr_hit),
    .clr_bits (wr_data_i[2:0]),
    .ro_wr    (ro_wr),
    .raw      (raw_q),
    .masked   (masked),
    .irq      (irq_q)
);

// File: tb/test_iss_top.sv
module test_iss_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_done = 1'b0, ev_rdy = 1'b0, ev_ovf = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    iss_top i_iss_top (
        .clk_i             (clk),
        .rst_ni            (rst_n),
        .evt_tx_done_i     (ev_done),
        .evt_rx_ready_i    (ev_rdy),
        .evt_rx_overflow_i (ev_ovf),
        .wr_en_i           (wr_en),
        .wr_addr_i         (wr_addr),
        .wr_data_i         (wr_data),
        .rd_addr_i         (rd_addr),
        .rd_data_o         (rd_data),
        .irq_o             (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse(input logic [2:0] p);
        @(negedge clk);
        {ev_ovf, ev_rdy, ev_done} = p;
        @(negedge clk);
        {ev_ovf, ev_rdy, ev_done} = 3'b000;
    endtask

    initial begin
        logic [31:0] d;
        logic [2:0]  expm;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        rd(3'd0, d); chk("R1 ctrl", d, 32'h8000_0102);
        rd(3'd4, d); chk("R1 raw", d, 0);
        rd(3'd3, d); chk("R1 masked", d, 0);
        rd(3'd1, d); chk("R1 status", d, 0);
        chk("R1 irq", {31'b0, irq}, 0);

        // R8: control readback
        wr(3'd0, 32'hDEAD_BEEF);
        rd(3'd0, d); chk("R8 ctrl readback", d, 32'hDEAD_BEEF);

        // R2 R5 R6 R9: sweep every raw pattern against every enable triple
        for (int e = 0; e < 8; e++) begin
            for (int p = 0; p < 8; p++) begin
                logic [2:0] pp, ee;
                pp = 3'(p); ee = 3'(e);
                wr(3'd2, 32'h7);
                wr(3'd0, 32'h8000_0102 | (32'(ee) << 4));
                @(negedge clk);
                pulse(pp);
                chk("R6 irq not yet", {31'b0, irq}, 0);
                expm = {pp[2] & ee[2], pp[1] & ee[0], pp[0] & ee[1]};
                rd(3'd4, d); chk("R2 raw", d, {29'b0, pp});
                rd(3'd3, d); chk("R5 masked", d, {29'b0, expm});
                @(negedge clk);
                chk("R6 irq", {31'b0, irq}, {31'b0, |expm});
                rd(3'd1, d); chk("R9 status", d, {28'b0, |expm, pp});
            end
        end

        // R3: selective clear
        wr(3'd0, 32'h70);
        pulse(3'b111);
        wr(3'd2, 32'hFFFF_FFF2);
        rd(3'd4, d); chk("R3 clear bit1", d, 32'h5);
        wr(3'd2, 32'h0);
        rd(3'd4, d); chk("R3 zero clear", d, 32'h5);
        // R2: sticky after many idle cycles
        repeat (10) @(negedge clk);
        rd(3'd4, d); chk("R2 sticky", d, 32'h5);

        // R7: read-only writes
        wr(3'd4, 32'h0);
        wr(3'd3, 32'h0);
        wr(3'd1, 32'h0);
        rd(3'd4, d); chk("R7 raw unchanged", d, 32'h5);
        rd(3'd0, d); chk("R7 ctrl unchanged", d, 32'h70);

        // R4: event and clear of the same bit in one cycle
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd2; wr_data = 32'h7; ev_done = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; ev_done = 1'b0;
        rd(3'd4, d); chk("R4 event wins", d, 32'h1);

        // R6: irq falls one clock after clear
        wr(3'd2, 32'h1);
        chk("R6 irq still high", {31'b0, irq}, 1);
        @(negedge clk);
        chk("R6 irq low", {31'b0, irq}, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule